// File: doc/BRIEF.md
# Pipelined Digital Lock-in Amplifier

This block recovers the in-phase and quadrature parts of a signal at a chosen reference frequency. It drives an excitation word to a DAC and reads back one ADC sample for each processing tick. One tick occurs every `TICK_DIV` system clocks, and every stage of the datapath advances once per tick.

A 32-bit phase accumulator, stepped by a run-time tuning word, addresses a quarter-wave sine table. The table is folded by quadrant. The cosine is the same lookup taken at a quarter-turn further on.

The datapath has three register stages, and each stage works on the previous tick's results:

- **Stage 1** captures the references together with the ADC sample.
- **Stage 2** forms three results:
  - the gain-scaled, saturated excitation word;
  - the rounded product of the sample with the sine;
  - the rounded product of the sample with the cosine.
- **Stage 3** smooths each product with a first-order leaky integrator. Its divisor is a power of two chosen at run time.

Top module: `lockin_amp`

## Requirements
- R1: A tick occurs once every TICK_DIV (default 8) clocks after reset. `xy_valid` is high for exactly one clock after each tick edge, starting with the third tick after reset, and is low at all other times.
- R2: The reference for phase p uses t = p[31:22]. Quadrant q = t[9:8] and r = t[7:0]. Let u = r when q is even and u = 256 − r when q is odd. The magnitude is floor(32767·u·(512−u)/65536), negated when q ≥ 2. The cosine uses p + 2^30. Stage 1 uses the phase before adding `ftw`, and the phase starts at 0.
- R3: `dac_out` = clamp(floor((sin·gain + 128)/256), −32768, 32767). Here `gain` is unsigned with 8 fraction bits, so 256 is unity.
- R4: Each product is floor((ref·sample + 16384)/32768), formed from the stage-1 reference and the stage-1 sample.
- R5: Each filter keeps a 32-bit state a, with the product placed in its top 16 bits. On each tick, a ← a + floor((product·65536 − a)/2^k), where k = `bw_shift`. The output is the top 16 bits of a. The output always lies between its previous value and the stage-2 product.
- R6: With `bw_shift` = 0, the filter outputs equal the previous tick's products. With a zero tuning word and a constant sample s, `x_out` = 0 and `y_out` = round(s·32767/32768).
- R7: A sample present at tick edge n shows in `x_out`/`y_out` after tick edge n+2. The outputs change only on tick edges.
- R8: While `rst_n` is low, `dac_out`, `x_out` and `y_out` are 0 and `xy_valid` is 0. All pipeline, phase and filter state also clears.
- R9: A change of `bw_shift`, `gain` or `ftw` between ticks takes effect at the next tick and does not clear the filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_in | input | 16 | Signed input sample |
| ftw | input | 32 | Phase step per tick |
| gain | input | 16 | Unsigned excitation gain, 8 fraction bits |
| bw_shift | input | 4 | Filter divisor exponent k (N = 2^k) |
| dac_out | output | 16 | Signed, saturated excitation word |
| x_out | output | 16 | Filtered in-phase result |
| y_out | output | 16 | Filtered quadrature result |
| xy_valid | output | 1 | One-clock strobe per tick once the pipeline is full |

## Verification
The assertions assume that `bw_shift`, `gain`, `ftw` and `adc_in` change only between ticks. They also assume that reset is asserted long enough for every register to clear.

The bench changes inputs only on the falling edge just after a tick edge, so each tick sees one settled set of inputs. Its tick counting is aligned to the release of reset, which the bench also drives on a falling edge.

// File: rtl/lia_pkg.sv
package lia_pkg;

  // Parabolic quarter-wave sine: 0 at u=0, amp at u=q
  function automatic longint quarter_sine(longint u, longint q, longint amp);
    return (amp * u * (2 * q - u)) / (q * q);
  endfunction

  // Round-half-up arithmetic right shift
  function automatic longint round_shift(longint v, int sh);
    if (sh <= 0) return v;
    return (v + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  function automatic longint clamp(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/lia_tick_gen.sv
module lia_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lia_ref_gen.sv
module lia_ref_gen
  import lia_pkg::*;
#(
  parameter int PH_W     = 32,
  parameter int TAB_BITS = 8,
  parameter int OUT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [PH_W-1:0]         ftw,
  output logic signed [OUT_W-1:0] sin_q,
  output logic signed [OUT_W-1:0] cos_q
);
  localparam int        QSTEPS  = 1 << TAB_BITS;
  localparam longint    AMP     = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

  logic [OUT_W-1:0] qtab [QSTEPS+1];
  logic [PH_W-1:0]  phase;

  for (genvar g = 0; g <= QSTEPS; g++) begin : g_tab
    assign qtab[g] = OUT_W'(quarter_sine(longint'(g), longint'(QSTEPS), AMP));
  end

  function automatic logic signed [OUT_W-1:0] lookup(input logic [PH_W-1:0] p);
    logic [1:0]          quad;
    logic [TAB_BITS-1:0] rem;
    logic [TAB_BITS:0]   addr;
    logic [OUT_W-1:0]    mag;
    quad = p[PH_W-1 -: 2];
    rem  = p[PH_W-3 -: TAB_BITS];
    addr = quad[0] ? ((TAB_BITS+1)'(QSTEPS) - {1'b0, rem}) : {1'b0, rem};
    mag  = qtab[addr];
    return quad[1] ? -$signed(mag) : $signed(mag);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      sin_q <= '0;
      cos_q <= '0;
    end else if (en) begin
      sin_q <= lookup(phase);
      cos_q <= lookup(phase + QUARTER);
      phase <= phase + ftw;
    end
  end
endmodule

// File: rtl/lia_mix.sv
module lia_mix
  import lia_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] ref_sin,
  input  logic signed [DATA_W-1:0] ref_cos,
  input  logic signed [DATA_W-1:0] smp,
  input  logic [GAIN_W-1:0]        gain,
  output logic signed [DATA_W-1:0] dac_q,
  output logic signed [DATA_W-1:0] px_q,
  output logic signed [DATA_W-1:0] py_q
);
  localparam longint MAXV = (longint'(1) <<< (DATA_W - 1)) - 1;
  localparam longint MINV = -(longint'(1) <<< (DATA_W - 1));

  function automatic logic signed [DATA_W-1:0] mul_ref(input logic signed [DATA_W-1:0] r,
                                                       input logic signed [DATA_W-1:0] s);
    return DATA_W'(round_shift(longint'(r) * longint'(s), DATA_W - 1));
  endfunction

  function automatic logic signed [DATA_W-1:0] excite(input logic signed [DATA_W-1:0] r,
                                                      input logic [GAIN_W-1:0] g);
    return DATA_W'(clamp(round_shift(longint'(r) * longint'(g), GAIN_FRAC), MINV, MAXV));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
      px_q  <= '0;
      py_q  <= '0;
    end else if (en) begin
      dac_q <= excite(ref_sin, gain);
      px_q  <= mul_ref(ref_sin, smp);
      py_q  <= mul_ref(ref_cos, smp);
    end
  end
endmodule

// File: rtl/lia_iir.sv
module lia_iir #(
  parameter int IN_W  = 16,
  parameter int EXT_W = 16,
  parameter int K_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [K_W-1:0]         k,
  input  logic signed [IN_W-1:0] din,
  output logic signed [IN_W-1:0] dout
);
  localparam int ACC_W = IN_W + EXT_W;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   step;

  always_comb begin
    diff = $signed({din[IN_W-1], din, {EXT_W{1'b0}}}) - $signed({acc[ACC_W-1], acc});
    step = diff >>> k;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc + step[ACC_W-1:0];
  end

  assign dout = acc[ACC_W-1 -: IN_W];
endmodule

// File: rtl/lockin_amp.sv
module lockin_amp #(
  parameter int TICK_DIV  = 8,
  parameter int PH_W      = 32,
  parameter int TAB_BITS  = 8,
  parameter int DATA_W    = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int EXT_W     = 16,
  parameter int K_W       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] adc_in,
  input  logic [PH_W-1:0]          ftw,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [K_W-1:0]           bw_shift,
  output logic signed [DATA_W-1:0] dac_out,
  output logic signed [DATA_W-1:0] x_out,
  output logic signed [DATA_W-1:0] y_out,
  output logic                     xy_valid
);
  localparam int FILL = 2;

  logic                     stage_tick;
  logic signed [DATA_W-1:0] ref_sin, ref_cos, smp_q;
  logic signed [DATA_W-1:0] prod_arr [2];
  logic signed [DATA_W-1:0] filt_arr [2];
  logic signed [DATA_W-1:0] prod_x, prod_y;
  logic [1:0]               fill_cnt;

  lia_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(stage_tick)
  );

  lia_ref_gen #(.PH_W(PH_W), .TAB_BITS(TAB_BITS), .OUT_W(DATA_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(stage_tick), .ftw(ftw),
    .sin_q(ref_sin), .cos_q(ref_cos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          smp_q <= '0;
    else if (stage_tick) smp_q <= adc_in;
  end

  lia_mix #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_mix (
    .clk(clk), .rst_n(rst_n), .en(stage_tick),
    .ref_sin(ref_sin), .ref_cos(ref_cos), .smp(smp_q), .gain(gain),
    .dac_q(dac_out), .px_q(prod_arr[0]), .py_q(prod_arr[1])
  );

  for (genvar c = 0; c < 2; c++) begin : g_filt
    lia_iir #(.IN_W(DATA_W), .EXT_W(EXT_W), .K_W(K_W)) u_iir (
      .clk(clk), .rst_n(rst_n), .en(stage_tick), .k(bw_shift),
      .din(prod_arr[c]), .dout(filt_arr[c])
    );
  end

  assign prod_x = prod_arr[0];
  assign prod_y = prod_arr[1];
  assign x_out  = filt_arr[0];
  assign y_out  = filt_arr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      xy_valid <= 1'b0;
    end else begin
      xy_valid <= stage_tick && (fill_cnt == 2'(FILL));
      if (stage_tick && fill_cnt != 2'(FILL)) fill_cnt <= fill_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lockin_amp_chk.sv
module lockin_amp_chk #(
  parameter int TICK_DIV = 8,
  parameter int DATA_W   = 16,
  parameter int K_W      = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     xy_valid,
  input logic [K_W-1:0]           bw_shift,
  input logic signed [DATA_W-1:0] dac_out,
  input logic signed [DATA_W-1:0] x_out,
  input logic signed [DATA_W-1:0] y_out,
  input logic signed [DATA_W-1:0] prod_x,
  input logic signed [DATA_W-1:0] prod_y,
  input logic signed [DATA_W-1:0] ref_sin,
  input logic signed [DATA_W-1:0] ref_cos
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (gap == 16'(TICK_DIV - 1)));

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xy_valid |=> !xy_valid);

  p_ref_sym_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sin != MOST_NEG) && (ref_cos != MOST_NEG));

  p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_out));

  p_xy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(x_out) && $stable(y_out)));

  p_k0_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && bw_shift == '0) |=> (x_out == $past(prod_x) && y_out == $past(prod_y)));

  p_filter_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((x_out >= $past(x_out) && x_out <= $past(prod_x)) ||
              (x_out <= $past(x_out) && x_out >= $past(prod_x))));
endmodule

bind lockin_amp lockin_amp_chk #(.TICK_DIV(TICK_DIV), .DATA_W(DATA_W), .K_W(K_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(stage_tick), .xy_valid(xy_valid),
  .bw_shift(bw_shift), .dac_out(dac_out), .x_out(x_out), .y_out(y_out),
  .prod_x(prod_x), .prod_y(prod_y), .ref_sin(ref_sin), .ref_cos(ref_cos)
);

// File: tb/sim_lockin_amp.sv
`timescale 1ns/1ps
module sim_lockin_amp;
  localparam int CLK_PERIOD = 25;
  localparam int TDIV       = 8;

  typedef struct packed {
    logic [31:0] ftw;
    logic [15:0] gain;
    logic [3:0]  k;
    logic [15:0] adc;
    logic [7:0]  ticks;
  } scen_t;

  localparam int NSC = 6;
  localparam scen_t SCN [NSC] = '{
    '{32'h0000_0000, 16'd256,   4'd0,  16'd1000,   8'd6},
    '{32'h0400_0000, 16'd256,   4'd2,  16'd20000,  8'd40},
    '{32'h1000_0000, 16'd512,   4'd4,  16'hC568,   8'd30},
    '{32'h4000_0000, 16'd65535, 4'd1,  16'h8000,   8'd12},
    '{32'h0123_4567, 16'd100,   4'd15, 16'd32767,  8'd30},
    '{32'hC000_0000, 16'd0,     4'd3,  16'd12345,  8'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] adc_in = '0;
  logic [31:0] ftw = '0;
  logic [15:0] gain = '0;
  logic [3:0]  bw_shift = '0;
  logic signed [15:0] dac_out, x_out, y_out;
  logic xy_valid;

  int n_chk = 0, n_fail = 0;

  // model state
  longint m_ph, m_s1s, m_s1c, m_s1a, m_px, m_py, m_dac, m_ax, m_ay;
  int     m_ticks;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockin_amp u0 (
    .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .ftw(ftw), .gain(gain),
    .bw_shift(bw_shift), .dac_out(dac_out), .x_out(x_out), .y_out(y_out),
    .xy_valid(xy_valid)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_of(longint p);
    longint t, q, r, u, m;
    t = (p >> 22) & 1023;
    q = t / 256;
    r = t % 256;
    u = (q % 2 == 1) ? 256 - r : r;
    m = (32767 * u * (512 - u)) / 65536;
    return (q >= 2) ? -m : m;
  endfunction

  function automatic longint rsh(longint v, int s);
    return (v + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  task automatic model_reset();
    m_ph = 0; m_s1s = 0; m_s1c = 0; m_s1a = 0;
    m_px = 0; m_py = 0; m_dac = 0; m_ax = 0; m_ay = 0; m_ticks = 0;
  endtask

  task automatic model_tick();
    longint d;
    int k;
    k = int'(bw_shift);
    m_ax = m_ax + (((m_px <<< 16) - m_ax) >>> k);
    m_ay = m_ay + (((m_py <<< 16) - m_ay) >>> k);
    m_px = rsh(m_s1s * m_s1a, 15);
    m_py = rsh(m_s1c * m_s1a, 15);
    d = rsh(m_s1s * longint'(gain), 8);
    m_dac = (d > 32767) ? 32767 : ((d < -32768) ? -32768 : d);
    m_s1s = ref_of(m_ph);
    m_s1c = ref_of((m_ph + 64'h4000_0000) & 64'hFFFF_FFFF);
    m_s1a = longint'(adc_in);
    m_ph  = (m_ph + longint'(ftw)) & 64'hFFFF_FFFF;
    m_ticks++;
  endtask

  // advance from a tick-aligned falling edge to the falling edge after the next tick
  task automatic one_tick();
    repeat (TDIV - 1) @(negedge clk);
    check("R1 valid low between ticks", longint'(xy_valid), 0);
    @(negedge clk);
    model_tick();
    check("R1/R7 valid strobe", longint'(xy_valid), (m_ticks >= 3) ? 1 : 0);
    check("R3 dac word", longint'(dac_out), m_dac);
    check("R5/R9 x_out", longint'(x_out), m_ax >>> 16);
    check("R4/R5 y_out", longint'(y_out), m_ay >>> 16);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R8 dac in reset", longint'(dac_out), 0);
    check("R8 x in reset", longint'(x_out), 0);
    check("R8 y in reset", longint'(y_out), 0);
    check("R8 valid in reset", longint'(xy_valid), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int s = 0; s < NSC; s++) begin
      ftw = SCN[s].ftw; gain = SCN[s].gain; bw_shift = SCN[s].k;
      adc_in = $signed(SCN[s].adc);
      for (int t = 0; t < int'(SCN[s].ticks); t++) begin
        one_tick();
        // R2 reference: unity gain makes the dac word equal the sine reference
      end
      if (s == 0) begin
        check("R6 pass-through x", longint'(x_out), 0);
        check("R6 pass-through y", longint'(y_out), 1000);
        check("R2 unity gain at phase 0", longint'(dac_out), 0);
      end
      if (s == 5) check("R3 zero gain", longint'(dac_out), 0);
    end
    // R9: bandwidth change mid-stream keeps state, model continues
    bw_shift = 4'd0;
    one_tick();
    bw_shift = 4'd6; adc_in = -16'sd7000;
    for (int t = 0; t < 8; t++) one_tick();
    // R8/R1: reset mid-run, then refill
    do_reset();
    ftw = 32'h0800_0000; gain = 16'd256; bw_shift = 4'd0; adc_in = 16'sd4096;
    for (int t = 0; t < 6; t++) one_tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule